// File: doc/BRIEF.md
# Wide Floating-Point Multiplier with Karatsuba Mantissa Product

This block multiplies two very wide floating-point words and streams out their product. A word holds a sign in its top bit, a 63-bit biased exponent below it, and a mantissa in every remaining low bit. The mantissa carries an implicit leading one. The significand product is formed by a recursive Karatsuba split. Each split level divides both operands into halves and forms three half-size products: high by high, low by low, and sum of halves by sum of halves. The cross term is recovered by subtraction. The recursion ends once the operand width is at or below a configurable base width, and a direct multiply is used there.

The datapath is fully pipelined. One operand pair can enter on every clock, and results leave in input order after a fixed latency. The stream carries a valid qualifier only. There is no ready signal and no back-pressure: the block never stalls, and the consumer must take every result in the cycle in which `out_valid` is high. Infinities, NaNs, subnormals and exponent overflow are not handled. The exponent simply wraps modulo 2^63.

Top module: `wfp_mul_kara`

## Requirements
- R1: With word width W (a multiple of 512, default 512), bit W-1 is the sign, bits W-2 down to W-64 are the exponent, and bits W-65 down to 0 are the mantissa (448 bits by default). The significand is the mantissa with a one prepended above its top bit.
- R2: For a non-zero result, the result sign is the XOR of the two input signs.
- R3: For a non-zero result, the result exponent is ea + eb - (2^62 - 1), plus one when the significand product is 2 or more, taken modulo 2^63.
- R4: The result mantissa is the significand product, shifted right by one place when it is 2 or more, with the leading one dropped and the bits below the mantissa width discarded (truncation toward zero).
- R5: If either operand has all exponent and mantissa bits zero (with either sign bit), the whole result word is zero.
- R6: `out_valid` is high exactly LATENCY cycles after `in_valid` was sampled high, and low otherwise. LATENCY is the number of Karatsuba split levels plus 2. The default is 5 (449-bit significand, base width 64).
- R7: A new operand pair is accepted on every cycle, including long back-to-back runs, and each result stays matched to its own inputs.
- R8: An active-high synchronous reset clears every valid stage. Pairs that are in flight when reset is applied never produce `out_valid`, and `out_valid` stays low during reset.
- R9: The numeric result does not depend on the base width parameter. With a base width of 128 the latency becomes 4 and the products are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid stages |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is present this cycle |
| in_a | input | W | First operand word |
| in_b | input | W | Second operand word |
| out_valid | output | 1 | `out_p` holds a product this cycle |
| out_p | output | W | Product word |

## Verification
The bound checker watches the valid timing on every cycle: the output valid must match the input valid delayed by LATENCY, and reset must clear it. It also checks that a zero operand yields an all-zero word and that the result sign is the XOR of the input signs. The exponent arithmetic, the normalization choice and the Karatsuba mantissa bits can only be shown by the bench. The bench compares every result against a wide direct multiply. It covers corner significands (all ones, the implicit one alone), exponent wrap-around, zero operands, gapped and back-to-back streams, and a reset with pairs in flight. It runs these on two instances that differ in base width.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  localparam int EXP_W = 63;

  // Number of Karatsuba split levels for an operand of width w.
  // Each split feeds children of width ceil(w/2)+1; base must be >= 4.
  function automatic int kara_levels(input int w, input int base);
    int cur;
    int lv;
    cur = w;
    lv  = 0;
    while (cur > base) begin
      cur = (cur - cur / 2) + 1;
      lv  = lv + 1;
    end
    return lv;
  endfunction
endpackage

// File: rtl/kara_mul.sv
// Recursive pipelined Karatsuba multiplier. Latency = split levels + 1.
module kara_mul #(
  parameter int WIDTH = 449,
  parameter int BASE  = 64
) (
  input  logic               clk,
  input  logic [WIDTH-1:0]   a,
  input  logic [WIDTH-1:0]   b,
  output logic [2*WIDTH-1:0] p
);
  generate
    if (WIDTH <= BASE) begin : g_leaf
      logic [2*WIDTH-1:0] a_x, b_x;
      assign a_x = {{WIDTH{1'b0}}, a};
      assign b_x = {{WIDTH{1'b0}}, b};
      always_ff @(posedge clk) p <= a_x * b_x;
    end else begin : g_split
      localparam int LO = WIDTH / 2;
      localparam int HI = WIDTH - LO;
      localparam int S  = HI + 1;
      localparam int PW = 2 * S;
      localparam int TW = 2 * WIDTH + 4;

      logic [S-1:0]  ah, al, asum, bh, bl, bsum;
      logic [PW-1:0] p_hh, p_ll, p_mm;
      logic [TW-1:0] x_hh, x_ll, x_mm, x_mid, x_sum;
      logic          unused_hi;

      assign ah   = {1'b0, a[WIDTH-1:LO]};
      assign al   = {{(S-LO){1'b0}}, a[LO-1:0]};
      assign bh   = {1'b0, b[WIDTH-1:LO]};
      assign bl   = {{(S-LO){1'b0}}, b[LO-1:0]};
      assign asum = ah + al;
      assign bsum = bh + bl;

      kara_mul #(.WIDTH(S), .BASE(BASE)) u_hh (.clk(clk), .a(ah),   .b(bh),   .p(p_hh));
      kara_mul #(.WIDTH(S), .BASE(BASE)) u_ll (.clk(clk), .a(al),   .b(bl),   .p(p_ll));
      kara_mul #(.WIDTH(S), .BASE(BASE)) u_mm (.clk(clk), .a(asum), .b(bsum), .p(p_mm));

      assign x_hh  = {{(TW-PW){1'b0}}, p_hh};
      assign x_ll  = {{(TW-PW){1'b0}}, p_ll};
      assign x_mm  = {{(TW-PW){1'b0}}, p_mm};
      assign x_mid = x_mm - x_hh - x_ll;
      assign x_sum = (x_hh << (2 * LO)) + (x_mid << LO) + x_ll;
      assign unused_hi = ^x_sum[TW-1:2*WIDTH];

      always_ff @(posedge clk) p <= x_sum[2*WIDTH-1:0];
    end
  endgenerate
endmodule

// File: rtl/pipe_delay.sv
// Fixed-depth delay line: valid bit is reset, payload is not.
module pipe_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d_valid,
  input  logic [WIDTH-1:0] d_data,
  output logic             q_valid,
  output logic [WIDTH-1:0] q_data
);
  logic [DEPTH-1:0] vst;
  logic [WIDTH-1:0] dst [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) vst[0] <= 1'b0;
          else     vst[0] <= d_valid;
        end
        always_ff @(posedge clk) dst[0] <= d_data;
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) vst[i] <= 1'b0;
          else     vst[i] <= vst[i-1];
        end
        always_ff @(posedge clk) dst[i] <= dst[i-1];
      end
    end
  endgenerate

  assign q_valid = vst[DEPTH-1];
  assign q_data  = dst[DEPTH-1];
endmodule

// File: rtl/wfp_mul_kara.sv
module wfp_mul_kara #(
  parameter int W    = 512,
  parameter int BASE = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_p
);
  import fpk_pkg::*;

  localparam int MW      = W - 1 - EXP_W;
  localparam int SW      = MW + 1;
  localparam int KLAT    = kara_levels(SW, BASE) + 1;
  localparam int LATENCY = KLAT + 1;
  localparam int SBW     = EXP_W + 2;
  localparam logic [EXP_W-1:0] BIAS = {1'b0, {(EXP_W-1){1'b1}}};

  // Operand decode
  logic [EXP_W-1:0] ea, eb, esum;
  logic [SW-1:0]    sig_a, sig_b;
  logic             zero_in, sign_in;

  assign ea      = in_a[W-2 -: EXP_W];
  assign eb      = in_b[W-2 -: EXP_W];
  assign sig_a   = {1'b1, in_a[MW-1:0]};
  assign sig_b   = {1'b1, in_b[MW-1:0]};
  assign zero_in = (in_a[W-2:0] == '0) || (in_b[W-2:0] == '0);
  assign sign_in = in_a[W-1] ^ in_b[W-1];
  assign esum    = ea + eb - BIAS;

  // Significand product
  logic [2*SW-1:0] prod;
  kara_mul #(.WIDTH(SW), .BASE(BASE)) u_kmul (
    .clk(clk), .a(sig_a), .b(sig_b), .p(prod)
  );

  // Sideband aligned with the product
  logic           v_d;
  logic [SBW-1:0] sb_d;
  pipe_delay #(.WIDTH(SBW), .DEPTH(KLAT)) u_side (
    .clk(clk), .rst(rst),
    .d_valid(in_valid), .d_data({sign_in, zero_in, esum}),
    .q_valid(v_d), .q_data(sb_d)
  );

  // Normalize and truncate
  logic             top;
  logic [MW-1:0]    mant_n;
  logic [EXP_W-1:0] exp_n;
  logic             unused_lo;

  assign top       = prod[2*SW-1];
  assign mant_n    = top ? prod[2*SW-2 -: MW] : prod[2*SW-3 -: MW];
  assign exp_n     = sb_d[EXP_W-1:0] + {{(EXP_W-1){1'b0}}, top};
  assign unused_lo = ^prod[MW-1:0];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v_d;
  end

  always_ff @(posedge clk) begin
    if (sb_d[EXP_W]) out_p <= '0;
    else             out_p <= {sb_d[EXP_W+1], exp_n, mant_n};
  end
endmodule

// File: rtl/wfp_mul_kara_chk.sv
module wfp_mul_kara_chk #(
  parameter int W   = 512,
  parameter int LAT = 5
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic [W-1:0] out_p
);
  logic [LAT-1:0] cv, cz, cs;

  always_ff @(posedge clk) begin
    if (rst) cv <= '0;
    else     cv <= {cv[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    cz <= {cz[LAT-2:0], (in_a[W-2:0] == '0) || (in_b[W-2:0] == '0)};
    cs <= {cs[LAT-2:0], in_a[W-1] ^ in_b[W-1]};
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == cv[LAT-1]);

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R5
  zero_out_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cz[LAT-1]) |-> (out_p == '0));

  // R2
  sign_xor_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cz[LAT-1]) |-> (out_p[W-1] == cs[LAT-1]));
endmodule

bind wfp_mul_kara wfp_mul_kara_chk #(.W(W), .LAT(LATENCY)) u_chk (.*);

// File: tb/tb_wfp_mul_kara.sv
module tb_wfp_mul_kara;
  localparam int W      = 512;
  localparam int MW     = 448;
  localparam int LAT_A  = 5;   // R6: 3 split levels + 2 at base 64
  localparam int LAT_B  = 4;   // R9: 2 split levels + 2 at base 128
  localparam int HN     = 4096;
  localparam logic [62:0] BIAS = {1'b0, {62{1'b1}}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic out_valid_a, out_valid_b;
  logic [W-1:0] out_a, out_b;

  int nchk = 0, nfail = 0, cyc = 0, rst_step = 0;
  bit done = 1'b0;
  logic         hist_v [HN];
  logic [W-1:0] hist_w [HN];

  always #5 clk = ~clk;

  wfp_mul_kara #(.W(W), .BASE(64)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid_a), .out_p(out_a));

  wfp_mul_kara #(.W(W), .BASE(128)) dut_b (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid_b), .out_p(out_b));

  // Reference: direct wide multiply of significands (R1, R3, R4, R5)
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*MW+1:0] xa, xb, pr;
    logic [62:0] e;
    logic t;
    if (a[W-2:0] == '0 || b[W-2:0] == '0) return '0;
    xa = {{(MW+1){1'b0}}, 1'b1, a[MW-1:0]};
    xb = {{(MW+1){1'b0}}, 1'b1, b[MW-1:0]};
    pr = xa * xb;
    t  = pr[2*MW+1];
    e  = a[W-2 -: 63] + b[W-2 -: 63] - BIAS + {62'd0, t};
    return {a[W-1] ^ b[W-1], e, t ? pr[2*MW -: MW] : pr[2*MW-1 -: MW]};
  endfunction

  function automatic logic [W-1:0] rnd();
    logic [W-1:0] w;
    for (int i = 0; i < W / 32; i++) w[i*32 +: 32] = $urandom;
    return w;
  endfunction

  function automatic logic [W-1:0] mk(input logic s, input logic [62:0] e, input logic [MW-1:0] m);
    return {s, e, m};
  endfunction

  task automatic check_one(input string who, input int lat, input logic ov, input logic [W-1:0] op);
    int idx;
    logic ev;
    logic [W-1:0] ew;
    string tag;
    idx = cyc - lat;
    ev  = (idx >= 0) ? hist_v[idx] : 1'b0;
    ew  = (idx >= 0) ? hist_w[idx] : '0;
    tag = (cyc - rst_step <= lat) ? "R8" : "R6";
    nchk++;
    if (ov !== ev) begin
      nfail++;
      $display("FAIL %s %s out_valid got %0b exp %0b at step %0d", tag, who, ov, ev, cyc);
    end
    if (ev) begin
      nchk++;
      if (op !== ew) begin
        nfail++;
        if (ew == '0)                  tag = "R5";
        else if (op[W-1] !== ew[W-1])  tag = "R2";
        else if (op[W-2 -: 63] !== ew[W-2 -: 63]) tag = "R3";
        else                           tag = "R4";
        if (lat == LAT_B) tag = {"R9/", tag};
        $display("FAIL %s %s step %0d got %h exp %h", tag, who, cyc, op, ew);
      end
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    check_one("dut", LAT_A, out_valid_a, out_a);
    check_one("dut_b", LAT_B, out_valid_b, out_b);
    rst = r; in_valid = v; in_a = a; in_b = b;
    hist_v[cyc] = v && !r;
    hist_w[cyc] = model(a, b);
    if (r) begin
      rst_step = cyc;
      for (int k = cyc - 4; k <= cyc; k++) if (k >= 0) hist_v[k] = 1'b0;
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
  endtask

  initial begin : wdog
    #(200000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired at step %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin : stim
    logic [MW-1:0] ones;
    ones = '1;
    // R8: out_valid low throughout reset
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, rnd(), rnd());
    // Corners (R1..R5): 1.0*1.0, all-ones normalization, signs, zeros, wrap
    step(1'b0, 1'b1, mk(0, BIAS, '0), mk(0, BIAS, '0));
    step(1'b0, 1'b1, mk(0, BIAS, ones), mk(1, BIAS, ones));
    step(1'b0, 1'b1, mk(1, 63'd5, ones), mk(1, BIAS, '0));
    step(1'b0, 1'b1, mk(1, 63'd0, '0), rnd());
    step(1'b0, 1'b1, rnd(), mk(0, 63'd0, '0));
    step(1'b0, 1'b1, mk(0, '1, ones), mk(1, '1, ones));
    step(1'b0, 1'b1, mk(0, 63'd0, 448'd1), mk(0, 63'd0, 448'd1));
    step(1'b0, 1'b1, mk(1, 63'd1, {1'b1, 447'd0}), mk(0, 63'd2, {1'b1, 447'd0}));
    idle(6);
    // R7: long back-to-back burst
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, rnd(), rnd());
    // Gapped random stream
    for (int i = 0; i < 1200; i++) begin
      logic [1:0] g;
      g = 2'($urandom);
      step(1'b0, g != 2'd0, rnd(), rnd());
    end
    // R8: reset with pairs in flight, then resume
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, rnd(), rnd());
    step(1'b1, 1'b1, rnd(), rnd());
    step(1'b1, 1'b0, rnd(), rnd());
    for (int i = 0; i < 100; i++) step(1'b0, 1'b1, rnd(), rnd());
    idle(LAT_A + 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule